// File: doc/BRIEF.md
# AXI4 Burst Read Memory Slave

This block answers AXI4 read bursts from a small on-chip RAM. A manager places a request on the read-address channel (ID, byte address, beat count minus one, beat size, burst kind). The block buffers up to two such requests, serves them strictly in the order they were taken, and sends one full-width data beat per transfer on the read-data channel. Each beat carries the request ID, an OKAY response and a final-beat flag. Both channels use valid/ready handshakes.

Within a burst the address steps by the beat size. Fixed bursts repeat one address. Incrementing bursts walk upward. Wrapping bursts fold back to the start of their aligned window. Each beat returns the whole aligned bus word that holds the current address, even for narrow beats. The word index is taken modulo the RAM depth. A second, plain write port with byte enables shares the same storage, so a write-side agent or a loader can fill it.

The RAM read takes one cycle. A two-entry response buffer with issue credits lets the read pipeline stall under backpressure without losing or repeating a beat.

Top module: `axiRdRam`

## Requirements
- R1: When every request is at least four beats long and the read-data channel is held stalled, exactly three requests are taken (one in service, two buffered), and `arReady` then stays low.
- R2: A request with length field L yields exactly L+1 beats, and `rLast` is high on the last beat only (for L=0, on the single beat).
- R3: Burst kind code 2'b01 (incrementing) starts at the request address rounded down to a multiple of 2^size bytes and adds 2^size per beat. Every beat carries the full bus word holding the current address, with byte k of the word on data bits [8k+7:8k] (little-endian).
- R4: Every beat carries `rId` equal to the ID of its request and `rResp` equal to 2'b00 (OKAY).
- R5: While `rValid` is high and `rReady` is low, `rValid`, `rData`, `rLast` and `rId` hold their values. No beat is dropped or repeated whatever the `rReady` pattern.
- R6: Burst kind code 2'b00 (fixed) returns the word at the rounded-down start address on every beat.
- R7: Burst kind code 2'b10 (wrapping, lengths 2, 4, 8 or 16 beats) steps like R3, but returns to the window's lower bound, the start rounded down to beats×2^size, when the address reaches the upper bound.
- R8: The RAM word read is (address / bus bytes) modulo the RAM depth in words, so addresses past the RAM size alias to its start.
- R9: A write-port cycle with `wrEn` high updates only the byte lanes whose `wrStrb` bit is set, in the word selected by `wrAddr` (the same mapping as R8). Other lanes keep their old contents.
- R10: Reset drops the burst in service, the buffered requests and any pending beats. After reset, `rValid` is low, `arReady` is high, and the next request's beats come first.
- R11: Bursts are returned in the order their requests were accepted, with no interleaving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| arValid | input | 1 | Read request valid |
| arReady | output | 1 | Read request accepted this cycle when valid |
| arId | input | ID_W | Request ID |
| arAddr | input | ADDR_W | Request start byte address |
| arLen | input | 8 | Beats minus one |
| arSize | input | 3 | log2 of bytes per beat (capped at bus width) |
| arBurst | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping |
| rValid | output | 1 | Read beat valid |
| rReady | input | 1 | Read beat taken |
| rId | output | ID_W | ID of the request the beat belongs to |
| rData | output | DATA_W | Full aligned bus word |
| rResp | output | 2 | Response code, always OKAY |
| rLast | output | 1 | Final beat of the burst |
| wrEn | input | 1 | Shared write port enable |
| wrAddr | input | ADDR_W | Write byte address (word selected as in R8) |
| wrData | input | DATA_W | Write data |
| wrStrb | input | DATA_W/8 | Per-lane write enables |

## Verification
The bench builds the block with a 32-bit data bus, 16-bit addresses and a 256-byte RAM of 64 words. With this shallow depth, a burst starting at 0x1F8 runs past the RAM end and shows the modulo aliasing. The four byte lanes let beat sizes of one, two and four bytes produce narrow, unaligned and wrapping sequences whose full-word returns can be told apart. Backpressure uses steady, alternating and one-in-three ready patterns, and the three-request fill is reached by stalling the response side.

// File: rtl/axiRdPkg.sv
package axiRdPkg;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10
  } burstKind_e;

  // Strobes from the address engine to the datapath.
  typedef struct packed {
    logic issue;  // read the selected RAM word this cycle
    logic last;   // the word issued closes its burst
  } rdStrobe_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axiRdCtrl.sv
module axiRdCtrl
  import axiRdPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ID_W      = 4,
  parameter int BUS_BYTES = 4,
  parameter int RAM_WORDS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              arValid,
  output logic              arReady,
  input  logic [ID_W-1:0]   arId,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic [7:0]        arLen,
  input  logic [2:0]        arSize,
  input  logic [1:0]        arBurst,
  input  logic              slotFree,
  output rdStrobe_t         strobe,
  output logic [$clog2(RAM_WORDS)-1:0] rdWord,
  output logic [ID_W-1:0]   beatId
);

  localparam int LANE_AW = $clog2(BUS_BYTES);
  localparam int WORD_AW = $clog2(RAM_WORDS);
  localparam logic [2:0] MAX_SIZE = 3'(LANE_AW);

  // Two-entry request queue
  logic [ID_W-1:0]   qId    [2];
  logic [ADDR_W-1:0] qAddr  [2];
  logic [7:0]        qLen   [2];
  logic [2:0]        qSize  [2];
  burstKind_e        qBurst [2];
  logic              qWp, qRp;
  logic [1:0]        qCnt;
  logic              push, load;

  // Burst engine state
  logic              active;
  logic [ADDR_W-1:0] curAddr, stepBytes, wrapLow, wrapHigh, nextAddr, stepped;
  logic [7:0]        beatsLeft;
  logic [ID_W-1:0]   curId;
  burstKind_e        curBurst;
  logic              issue, isLast;

  // Decoded queue head
  logic [2:0]        hSize;
  logic [ADDR_W-1:0] hStep, hAligned, hXfer, hLow;

  assign arReady = (qCnt != 2'd2);
  assign push    = arValid && arReady;
  assign load    = !active && (qCnt != 2'd0);

  always_ff @(posedge clk) begin
    if (push) begin
      qId[qWp]    <= arId;
      qAddr[qWp]  <= arAddr;
      qLen[qWp]   <= arLen;
      qSize[qWp]  <= arSize;
      qBurst[qWp] <= burstKind_e'(arBurst);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qWp  <= 1'b0;
      qRp  <= 1'b0;
      qCnt <= 2'd0;
    end else begin
      if (push) qWp <= ~qWp;
      if (load) qRp <= ~qRp;
      qCnt <= qCnt + {1'b0, push} - {1'b0, load};
    end
  end

  always_comb begin
    hSize    = (qSize[qRp] > MAX_SIZE) ? MAX_SIZE : qSize[qRp];
    hStep    = ADDR_W'(1) << hSize;
    hAligned = qAddr[qRp] & ~(hStep - ADDR_W'(1));
    hXfer    = (ADDR_W'(qLen[qRp]) + ADDR_W'(1)) << hSize;
    hLow     = hAligned & ~(hXfer - ADDR_W'(1));
  end

  assign issue  = active && slotFree;
  assign isLast = (beatsLeft == 8'd0);

  always_comb begin
    stepped = curAddr + stepBytes;
    if (curBurst == BURST_FIXED)
      nextAddr = curAddr;
    else if (curBurst == BURST_WRAP && stepped == wrapHigh)
      nextAddr = wrapLow;
    else
      nextAddr = stepped;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      curAddr   <= '0;
      beatsLeft <= '0;
      curId     <= '0;
      curBurst  <= BURST_INCR;
      stepBytes <= '0;
      wrapLow   <= '0;
      wrapHigh  <= '0;
    end else if (load) begin
      active    <= 1'b1;
      curAddr   <= hAligned;
      beatsLeft <= qLen[qRp];
      curId     <= qId[qRp];
      curBurst  <= qBurst[qRp];
      stepBytes <= hStep;
      wrapLow   <= hLow;
      wrapHigh  <= hLow + hXfer;
    end else if (issue) begin
      if (isLast) active <= 1'b0;
      else        beatsLeft <= beatsLeft - 8'd1;
      curAddr <= nextAddr;
    end
  end

  assign strobe.issue = issue;
  assign strobe.last  = isLast;
  assign rdWord       = curAddr[LANE_AW +: WORD_AW];
  assign beatId       = curId;

endmodule

// File: rtl/axiRdDatapath.sv
module axiRdDatapath
  import axiRdPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int RAM_WORDS = 256
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rdStrobe_t                    strobe,
  input  logic [$clog2(RAM_WORDS)-1:0] rdWord,
  input  logic [ID_W-1:0]              beatId,
  input  logic                         wrEn,
  input  logic [$clog2(RAM_WORDS)-1:0] wrWord,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [DATA_W/8-1:0]          wrStrb,
  output logic                         slotFree,
  output logic                         rValid,
  input  logic                         rReady,
  output logic [ID_W-1:0]              rId,
  output logic [DATA_W-1:0]            rData,
  output logic                         rLast
);

  localparam int BUS_BYTES = DATA_W / 8;

  logic [DATA_W-1:0] mem [RAM_WORDS];
  logic [DATA_W-1:0] ramOut;

  // Word in flight from the RAM read stage
  logic              flV, flLast;
  logic [ID_W-1:0]   flId;

  // Two-slot response buffer
  logic [DATA_W-1:0] slotData [2];
  logic [ID_W-1:0]   slotId   [2];
  logic              slotLast [2];
  logic              sWp, sRp;
  logic [1:0]        sCnt;
  logic              sPush, sPop;
  logic [2:0]        level;

  always_ff @(posedge clk) begin
    if (wrEn) begin
      for (int b = 0; b < BUS_BYTES; b++) begin
        if (wrStrb[b]) mem[wrWord][b*8 +: 8] <= wrData[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.issue) begin
      ramOut <= mem[rdWord];
      flId   <= beatId;
      flLast <= strobe.last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) flV <= 1'b0;
    else       flV <= strobe.issue;
  end

  assign sPush = flV;
  assign sPop  = rValid && rReady;

  always_ff @(posedge clk) begin
    if (sPush) begin
      slotData[sWp] <= ramOut;
      slotId[sWp]   <= flId;
      slotLast[sWp] <= flLast;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sWp  <= 1'b0;
      sRp  <= 1'b0;
      sCnt <= 2'd0;
    end else begin
      if (sPush) sWp <= ~sWp;
      if (sPop)  sRp <= ~sRp;
      sCnt <= sCnt + {1'b0, sPush} - {1'b0, sPop};
    end
  end

  // Credit: buffered + in flight, minus the beat leaving now, must stay below two.
  assign level    = 3'(sCnt) + 3'(flV) - 3'(sPop);
  assign slotFree = (level < 3'd2);

  assign rValid = (sCnt != 2'd0);
  assign rData  = slotData[sRp];
  assign rId    = slotId[sRp];
  assign rLast  = slotLast[sRp];

endmodule

// File: rtl/axiRdRam.sv
module axiRdRam
  import axiRdPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int RAM_BYTES = 1024
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                arValid,
  output logic                arReady,
  input  logic [ID_W-1:0]     arId,
  input  logic [ADDR_W-1:0]   arAddr,
  input  logic [7:0]          arLen,
  input  logic [2:0]          arSize,
  input  logic [1:0]          arBurst,
  output logic                rValid,
  input  logic                rReady,
  output logic [ID_W-1:0]     rId,
  output logic [DATA_W-1:0]   rData,
  output logic [1:0]          rResp,
  output logic                rLast,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W/8-1:0] wrStrb
);

  localparam int BUS_BYTES = DATA_W / 8;
  localparam int RAM_WORDS = RAM_BYTES / BUS_BYTES;
  localparam int LANE_AW   = $clog2(BUS_BYTES);
  localparam int WORD_AW   = $clog2(RAM_WORDS);

  rdStrobe_t          strobe;
  logic [WORD_AW-1:0] rdWord;
  logic [ID_W-1:0]    beatId;
  logic               slotFree;

  axiRdCtrl #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .BUS_BYTES(BUS_BYTES), .RAM_WORDS(RAM_WORDS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .arValid(arValid), .arReady(arReady), .arId(arId), .arAddr(arAddr),
    .arLen(arLen), .arSize(arSize), .arBurst(arBurst),
    .slotFree(slotFree), .strobe(strobe), .rdWord(rdWord), .beatId(beatId)
  );

  axiRdDatapath #(
    .DATA_W(DATA_W), .ID_W(ID_W), .RAM_WORDS(RAM_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .rdWord(rdWord), .beatId(beatId),
    .wrEn(wrEn), .wrWord(wrAddr[LANE_AW +: WORD_AW]), .wrData(wrData), .wrStrb(wrStrb),
    .slotFree(slotFree),
    .rValid(rValid), .rReady(rReady), .rId(rId), .rData(rData), .rLast(rLast)
  );

  assign rResp = RESP_OKAY;

endmodule

// File: rtl/axiRdRamChk.sv
module axiRdRamChk #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              arValid,
  input logic              arReady,
  input logic [ID_W-1:0]   arId,
  input logic              rValid,
  input logic              rReady,
  input logic [ID_W-1:0]   rId,
  input logic [DATA_W-1:0] rData,
  input logic              rLast
);

  // Accepted-request IDs in order; at most five requests can be open at once.
  logic [ID_W-1:0] expIds [8];
  logic [2:0]      eWp, eRp;
  logic [3:0]      open;
  logic            took, closed;

  assign took   = arValid && arReady;
  assign closed = rValid && rReady && rLast;

  always_ff @(posedge clk) begin
    if (took) expIds[eWp] <= arId;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eWp  <= '0;
      eRp  <= '0;
      open <= '0;
    end else begin
      if (took)   eWp <= eWp + 3'd1;
      if (closed) eRp <= eRp + 3'd1;
      open <= open + {3'd0, took} - {3'd0, closed};
    end
  end

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    rValid && !rReady |=> rValid && $stable(rData) && $stable(rLast) && $stable(rId));

  // R4 and R11: beats carry the ID of the oldest open request
  p_id_in_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> rId == expIds[eRp]);

  p_beat_owned_r2: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> open != 4'd0);

  p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !rValid && arReady);

endmodule

bind axiRdRam axiRdRamChk #(.ID_W(ID_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .arValid(arValid), .arReady(arReady), .arId(arId),
  .rValid(rValid), .rReady(rReady), .rId(rId), .rData(rData), .rLast(rLast)
);

// File: tb/axiRdRam_tb.sv
`timescale 1ns/1ps
module axiRdRam_tb;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int ID_W   = 4;
  localparam int RAM_B  = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arValid = 1'b0, arReady;
  logic [ID_W-1:0] arId = '0;
  logic [ADDR_W-1:0] arAddr = '0;
  logic [7:0] arLen = '0;
  logic [2:0] arSize = '0;
  logic [1:0] arBurst = '0;
  logic rValid, rReady = 1'b0, rLast;
  logic [ID_W-1:0] rId;
  logic [DATA_W-1:0] rData;
  logic [1:0] rResp;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [3:0] wrStrb = '0;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] model [RAM_B];

  always #10 clk = ~clk;

  axiRdRam #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .RAM_BYTES(RAM_B)) u_dut (
    .clk(clk), .rstN(rstN), .arValid(arValid), .arReady(arReady), .arId(arId),
    .arAddr(arAddr), .arLen(arLen), .arSize(arSize), .arBurst(arBurst),
    .rValid(rValid), .rReady(rReady), .rId(rId), .rData(rData), .rResp(rResp),
    .rLast(rLast), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrStrb(wrStrb)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input int a);
    int w = (a >> 2) % (RAM_B / 4);
    return {model[w*4+3], model[w*4+2], model[w*4+1], model[w*4]};
  endfunction

  task automatic writeWord(input int a, input logic [31:0] d, input logic [3:0] s);
    int w = (a >> 2) % (RAM_B / 4);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 16'(a); wrData = d; wrStrb = s;
    @(negedge clk);
    wrEn = 1'b0;
    for (int b = 0; b < 4; b++) if (s[b]) model[w*4+b] = d[b*8 +: 8];
  endtask

  task automatic sendAr(input int id, input int a, input int len, input int sz, input int bk);
    bit ok = 0;
    @(negedge clk);
    arValid = 1'b1; arId = 4'(id); arAddr = 16'(a); arLen = 8'(len);
    arSize = 3'(sz); arBurst = 2'(bk);
    for (int c = 0; c < 50; c++) begin
      ok = arReady;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    arValid = 1'b0;
    if (!ok) check(1'b0, "R1", "request never accepted", 0, 1);
  endtask

  // Collects one burst, checking every beat against the address rules.
  task automatic collect(input int id, input int a, input int len, input int sz,
                         input int bk, input int mode, input string tag);
    int step = 1 << sz;
    int cur = a & ~(step - 1);
    int xfer = step * (len + 1);
    int low = cur & ~(xfer - 1);
    int high = low + xfer;
    int beat = 0, k = 0, waitc = 0;
    bit held = 0, rdy, v, l;
    logic [31:0] d, hd;
    logic [3:0] i;
    logic [1:0] rs;
    while (beat <= len && waitc < 400) begin
      @(negedge clk);
      if (held)
        check(rValid === 1'b1 && rData === hd && rLast === l, "R5", "value moved during stall",
              rData, hd);
      rdy = (mode == 0) ? 1'b1 : (mode == 1) ? (k % 2 == 1) : (k % 3 == 2);
      k++;
      rReady = rdy;
      v = rValid; d = rData; l = rLast; i = rId; rs = rResp;
      held = v && !rdy; hd = d;
      @(posedge clk);
      waitc++;
      if (v && rdy) begin
        check(d === expWord(cur), tag, $sformatf("data beat %0d addr %0h", beat, cur), d, expWord(cur));
        check(i === 4'(id), "R4", "beat ID", i, id);
        check(rs === 2'b00, "R4", "response code", rs, 0);
        check(l === (beat == len), "R2", $sformatf("last flag beat %0d", beat), l, beat == len);
        if (bk != 0) cur = (cur + step) & 16'hFFFF;
        if (bk == 2 && cur == high) cur = low;
        beat++;
      end
    end
    if (beat <= len) check(1'b0, tag, "beats missing", beat, len + 1);
    @(negedge clk);
    rReady = 1'b0;
  endtask

  task automatic tReset;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rValid === 1'b0, "R10", "rValid after reset", rValid, 0);
    check(arReady === 1'b1, "R10", "arReady after reset", arReady, 1);
  endtask

  task automatic tPreload;
    for (int w = 0; w < RAM_B / 4; w++) begin
      logic [31:0] d;
      for (int b = 0; b < 4; b++) d[b*8 +: 8] = 8'((w * 4 + b) * 13 + 7);
      writeWord(w * 4, d, 4'hF);
    end
  endtask

  task automatic tIncr;
    sendAr(1, 16'h10, 3, 2, 1);  collect(1, 16'h10, 3, 2, 1, 0, "R3");
    sendAr(2, 16'h21, 5, 0, 1);  collect(2, 16'h21, 5, 0, 1, 0, "R3");
    sendAr(3, 16'h33, 4, 1, 1);  collect(3, 16'h33, 4, 1, 1, 0, "R3");
    sendAr(4, 16'h44, 0, 2, 1);  collect(4, 16'h44, 0, 2, 1, 0, "R2");
  endtask

  task automatic tFixed;
    sendAr(5, 16'h2A, 3, 1, 0);  collect(5, 16'h2A, 3, 1, 0, 0, "R6");
  endtask

  task automatic tWrap;
    sendAr(6, 16'h38, 3, 2, 2);  collect(6, 16'h38, 3, 2, 2, 0, "R7");
    sendAr(7, 16'h4A, 7, 1, 2);  collect(7, 16'h4A, 7, 1, 2, 0, "R7");
  endtask

  task automatic tAlias;
    sendAr(8, 16'h1F8, 3, 2, 1); collect(8, 16'h1F8, 3, 2, 1, 0, "R8");
  endtask

  task automatic tBackpressure;
    sendAr(9, 16'h60, 7, 2, 1);  collect(9, 16'h60, 7, 2, 1, 1, "R5");
    sendAr(10, 16'h80, 5, 2, 1); collect(10, 16'h80, 5, 2, 1, 2, "R5");
  endtask

  task automatic tStrobe;
    writeWord(16'h20, 32'hA1B2C3D4, 4'b0101);
    sendAr(11, 16'h20, 0, 2, 1); collect(11, 16'h20, 0, 2, 1, 0, "R9");
  endtask

  task automatic tFill;
    int acc = 0;
    bit ok;
    rReady = 1'b0;
    @(negedge clk);
    arValid = 1'b1; arId = 4'd5; arAddr = 16'h00; arLen = 8'd3; arSize = 3'd2; arBurst = 2'd1;
    for (int c = 0; c < 12; c++) begin
      ok = arReady;
      @(posedge clk);
      if (ok) acc++;
      @(negedge clk);
      arId = 4'(5 + acc); arAddr = 16'(acc * 64);
    end
    check(acc == 3, "R1", "requests taken while stalled", acc, 3);
    check(arReady === 1'b0, "R1", "arReady with full buffer", arReady, 0);
    arValid = 1'b0;
    collect(5, 16'h00, 3, 2, 1, 0, "R11");
    collect(6, 16'h40, 3, 2, 1, 0, "R11");
    collect(7, 16'h80, 3, 2, 1, 0, "R11");
  endtask

  task automatic tMidReset;
    sendAr(12, 16'h40, 7, 2, 1);
    repeat (6) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(rValid === 1'b0, "R10", "stale beat after reset", rValid, 0);
      check(arReady === 1'b1, "R10", "arReady after reset", arReady, 1);
    end
    sendAr(13, 16'hC0, 1, 2, 1); collect(13, 16'hC0, 1, 2, 1, 0, "R10");
  endtask

  initial begin
    tReset();
    tPreload();
    tIncr();
    tFixed();
    tWrap();
    tAlias();
    tBackpressure();
    tStrobe();
    tFill();
    tMidReset();
    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog (all requirements): actual hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule